// File: doc/BRIEF.md
# Held-low RAM clear controller

This block turns a long press on an active-low clear button into a wipe of user storage. The raw button level is passed through a two-flop synchronizer. A hold counter then measures how long the synchronized level stays low without a break. When the low level has lasted `HOLD_CYCLES` clocks and main power is good, a sequencer starts. It writes 0xFF into every user storage byte, one byte per clock, and then pulses a strobe that zeroes the bank index registers.

The address space runs from 0 to `LAST_ADDR`. A protected window from `CTRL_LO` to `CTRL_HI` holds the clock and control registers, and the sequencer never writes there. With the default parameters this leaves 240 storage bytes: addresses 14 to 253.

After a clear has been triggered, the block does nothing more until the button has been released. A fresh full-length hold is then needed for the next clear. `HOLD_CYCLES` sets the required hold time in clock cycles. A real design sets it for about 125 ms at its clock rate, and a simulation can use a small value.

Top module: `ram_wipe_ctrl`

## Requirements
- R1: A clear starts only after the synchronized input has been low for `HOLD_CYCLES` consecutive clocks. When the input falls just after a clock edge, the first write is visible after the `HOLD_CYCLES+2`-th following rising edge.
- R2: If the input returns high before the hold count completes, even for a single clock, the count restarts from zero and nothing is written.
- R3: Once started, the block writes data 0xFF with `mem_we` high to every address from 0 to `LAST_ADDR` outside the protected window. It writes one address per clock, in ascending order, with no gaps in time.
- R4: Addresses `CTRL_LO` to `CTRL_HI`, which are 0 to 13 by default, are never written.
- R5: In the clock after the write to `LAST_ADDR`, `idx_clr` is high for exactly one cycle and `mem_we` is low in that cycle.
- R6: `busy` is high exactly in the cycles where `mem_we` or `idx_clr` is high, so from the first write through the index-clear cycle.
- R7: While `pwr_good` is low, the hold count is held at zero and no clear starts. If the input stays low and `pwr_good` rises just after an edge, the first write is visible after the `HOLD_CYCLES`-th following rising edge.
- R8: After a clear has been triggered, holding the input low longer starts no further clear. A new clear needs the input to go high and then meet the hold time again.
- R9: While in reset and right after it, `mem_we`, `idx_clr` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_btn_n | input | 1 | Raw active-low clear request (asynchronous) |
| pwr_good | input | 1 | Main power valid; gates recognition of the request |
| mem_addr | output | ADDR_W | Storage write address |
| mem_wdata | output | 8 | Storage write data (0xFF) |
| mem_we | output | 1 | Storage write enable |
| idx_clr | output | 1 | One-cycle strobe zeroing both bank index registers |
| busy | output | 1 | High while the clear sequence runs |

## Verification
The first write is due `HOLD_CYCLES+2` edges after the button falls: two edges are spent in the synchronizer and `HOLD_CYCLES` in the counter. After a power-good rise it is due `HOLD_CYCLES` edges later. Each later write follows one clock after the previous one, and the index strobe comes one clock after the last write. The bench drives inputs on falling edges and counts falling edges until `busy` is seen, so these latencies are compared exactly. A scoreboard queue holds the expected address sequence and the index-strobe marker. The monitor takes one entry off the queue for each write or strobe it sees on a falling edge, so a gap, a reordering or an extra write shows up as a mismatch or as an unexpected item.

// File: rtl/ram_wipe_ctrl.sv
module ram_wipe_ctrl #(
  parameter int HOLD_CYCLES = 31_250_000,
  parameter int ADDR_W      = 8,
  parameter int LAST_ADDR   = 253,
  parameter int CTRL_LO     = 0,
  parameter int CTRL_HI     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_btn_n,
  input  logic              pwr_good,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              idx_clr,
  output logic              busy
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0]     CNT_TOP    = CW'(HOLD_CYCLES - 1);
  localparam logic [ADDR_W-1:0] FIRST_ADDR = (CTRL_LO == 0) ? ADDR_W'(CTRL_HI + 1) : '0;
  localparam logic [ADDR_W-1:0] END_ADDR   = ADDR_W'(LAST_ADDR);
  localparam logic [ADDR_W-1:0] WIN_LO     = ADDR_W'(CTRL_LO);
  localparam logic [ADDR_W-1:0] WIN_HI     = ADDR_W'(CTRL_HI);

  typedef enum logic [1:0] {IDLE, FILL, IDX} state_t;

  logic          sync1, sync2, armed;
  logic [CW-1:0] hold_cnt;
  state_t        state;
  logic [ADDR_W-1:0] addr;
  logic          fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= clr_btn_n;
      sync2 <= sync1;
    end

  assign fire = !sync2 && pwr_good && armed && (state == IDLE) && (hold_cnt == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      hold_cnt <= '0;
    else if (sync2 || !pwr_good)
      hold_cnt <= '0;
    else if (hold_cnt != CNT_TOP)
      hold_cnt <= hold_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      armed <= 1'b1;
    else if (sync2)
      armed <= 1'b1;
    else if (fire)
      armed <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE;
      addr  <= '0;
    end else begin
      case (state)
        IDLE: if (fire) begin
          state <= FILL;
          addr  <= FIRST_ADDR;
        end
        FILL: begin
          if (addr == END_ADDR)
            state <= IDX;
          else if (addr + 1'b1 == WIN_LO)
            addr <= WIN_HI + 1'b1;
          else
            addr <= addr + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end

  assign mem_addr  = addr;
  assign mem_wdata = 8'hFF;
  assign mem_we    = (state == FILL);
  assign idx_clr   = (state == IDX);
  assign busy      = (state != IDLE);

  a_r4_window_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr < WIN_LO || mem_addr > WIN_HI));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr > $past(mem_addr)));

  a_r5_strobe_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idx_clr) |-> ($past(mem_we) && $past(mem_addr) == END_ADDR));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clr |=> !idx_clr);

  a_r7_start_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(pwr_good));

  a_r1_start_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(sync2));

  a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idx_clr) |-> !mem_we);
endmodule

// File: tb/ram_wipe_ctrl_tb_top.sv
module ram_wipe_ctrl_tb_top;
  localparam int H    = 20;
  localparam int LAST = 253;
  localparam int CLO  = 0;
  localparam int CHI  = 13;

  logic clk = 0, rst_n = 0, clr_btn_n = 1, pwr_good = 1;
  logic [7:0] mem_addr, mem_wdata;
  logic mem_we, idx_clr, busy;

  int errors = 0, checks = 0, writes = 0;
  bit done = 0;
  logic [8:0] expq[$];

  always #2 clk = ~clk;

  ram_wipe_ctrl #(.HOLD_CYCLES(H), .ADDR_W(8), .LAST_ADDR(LAST), .CTRL_LO(CLO), .CTRL_HI(CHI)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_btn_n(clr_btn_n), .pwr_good(pwr_good),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .idx_clr(idx_clr), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_clear();
    for (int a = 0; a <= LAST; a++)
      if (a < CLO || a > CHI) expq.push_back({1'b0, 8'(a)});
    expq.push_back(9'h100);
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (mem_we || idx_clr) begin
      logic [8:0] got, exp;
      got = {idx_clr, idx_clr ? 8'h00 : mem_addr};
      if (mem_we) writes++;
      chk(!(mem_we && idx_clr), "R5 write during strobe", mem_we, 0);
      if (mem_we) chk(mem_wdata == 8'hFF, "R3 data", mem_wdata, 255);
      if (expq.size() == 0) chk(0, "R2/R8 unexpected item", got, -1);
      else begin
        exp = expq.pop_front();
        chk(got == exp, "R3/R4/R5 sequence", got, exp);
      end
    end
    if (busy || mem_we || idx_clr)
      chk(busy == (mem_we || idx_clr), "R6 busy", busy, mem_we || idx_clr);
  end

  task automatic measure(input int exp_lat, input string req);
    int k = 0;
    while (!busy && k < exp_lat + 10) begin @(negedge clk); k++; end
    chk(k == exp_lat, req, k, exp_lat);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(expq.size() == 0, "R3 all storage bytes written", expq.size(), 0);
  endtask

  task automatic finish_up();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_we && !idx_clr && !busy, "R9 in reset", {mem_we, idx_clr, busy}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_we && !idx_clr && !busy, "R9 after reset", {mem_we, idx_clr, busy}, 0);

    // R2: one short of the hold time
    clr_btn_n = 0; repeat (H - 1) @(negedge clk); clr_btn_n = 1;
    repeat (H + 5) @(negedge clk);
    chk(writes == 0, "R2 short hold", writes, 0);

    // R2: two near-full holds split by a one-cycle release
    clr_btn_n = 0; repeat (H - 1) @(negedge clk); clr_btn_n = 1;
    @(negedge clk);
    clr_btn_n = 0; repeat (H - 1) @(negedge clk); clr_btn_n = 1;
    repeat (H + 5) @(negedge clk);
    chk(writes == 0, "R2 glitch restarts count", writes, 0);

    // R1: full hold, latency H+2
    push_clear();
    clr_btn_n = 0;
    measure(H + 2, "R1 start latency");
    chk(writes == 240, "R3 write count", writes, 240);

    // R8: stay held, no second clear
    repeat (3 * H) @(negedge clk);
    chk(writes == 240, "R8 held after clear", writes, 240);
    clr_btn_n = 1; repeat (4) @(negedge clk);

    // R8: release then full hold again
    push_clear();
    clr_btn_n = 0;
    measure(H + 2, "R8 second clear after release");
    chk(writes == 480, "R8 second clear count", writes, 480);
    clr_btn_n = 1; repeat (4) @(negedge clk);

    // R7: power not good blocks the request
    pwr_good = 0;
    clr_btn_n = 0;
    repeat (2 * H + 5) @(negedge clk);
    chk(writes == 480 && !busy, "R7 no clear without power", writes, 480);
    push_clear();
    pwr_good = 1;
    measure(H, "R7 latency after power good");
    chk(writes == 720, "R7 clear count", writes, 720);
    clr_btn_n = 1; repeat (4) @(negedge clk);

    finish_up();
  end
endmodule